// File: doc/BRIEF.md
# Lower-Level Cache Inclusion Controller

This block is the tag and sequencing controller for a cache that sits below one or more child caches. It tracks only tags, valid and dirty state for a direct-mapped array. It takes one child request at a time, decides hit or miss, and on a miss drives the requests needed toward its own parent. It then answers the child after a fixed per-command latency. No data is stored.

Two elaboration-time choices shape its behaviour. The inclusion policy is either inclusive, where fetched lines are kept here, or exclusive, where lines handed to a child leave this level. The write policy is either write-back, where written lines are held dirty until evicted, or write-through, where every write is forwarded upward. A child identifier travels with each request and is returned with the response, so that a shared parent-side controller can route answers.

Command codes on both the child and parent sides are 2'b00 fetch-read, 2'b01 fetch-write and 2'b10 write. Addresses are split into a byte offset of OFF_W low bits, an index of IDX_W bits above it, and the remaining high bits as the tag. All parent traffic carries line-aligned addresses, with the offset bits set to zero.

Top module: `lower_cache_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `par_req_valid` and `op_err` are 0; the tag array holds no valid line.
- R2: A request with code 2'b11 is accepted and dropped. `op_err` is 1 for exactly the cycle after acceptance. No response and no parent request follow, and the controller is ready again.
- R3: A fetch that hits produces `rsp_valid` LAT_FETCH cycles after the accepting edge, with no parent request.
- R4: A fetch lookup or fetch fill never marks a line dirty. A later eviction of such a line sends no write to the parent.
- R5: In exclusive mode, a fetch hit removes the line before the latency stall, so a repeated fetch to that address misses.
- R6: In inclusive mode, a fetch miss evicts the line at its index. A dirty victim is first written to the parent at the victim's line address. The fetch is then forwarded with its code unchanged, and the fetched line is installed clean.
- R7: In exclusive mode, a fetch miss neither evicts nor installs a line, so a resident line at that index keeps hitting.
- R8: Under write-back, a write that hits marks the line dirty, sends nothing to the parent, and responds LAT_WRITE cycles after acceptance.
- R9: Under write-through, a write that hits is forwarded as a write to the parent. The response comes LAT_WRITE cycles after the parent's write acknowledgement, and no line ever becomes dirty.
- R10: A write that misses evicts the indexed line, writing it back if dirty, and sends a fetch-write to the parent. On the reply the line is installed, dirty only under write-back. Under write-through the write is then forwarded.
- R11: Every response returns the request's child ID, command code and address.
- R12: Only one request is in flight. `req_ready` is 0 from acceptance until the response has been given, and a parent request is held stable while it is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Child request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_op | input | 2 | Child command code |
| req_id | input | ID_W | Requesting child identifier |
| req_addr | input | ADDR_W | Request byte address |
| rsp_valid | output | 1 | One-cycle response to the child |
| rsp_op | output | 2 | Command code being answered |
| rsp_id | output | ID_W | Child identifier being answered |
| rsp_addr | output | ADDR_W | Address being answered |
| par_req_valid | output | 1 | Request toward the parent |
| par_req_ready | input | 1 | Parent takes the request |
| par_req_op | output | 2 | Parent command code |
| par_req_addr | output | ADDR_W | Line-aligned parent address |
| par_rsp_valid | input | 1 | Parent reply present |
| par_rsp_op | input | 2 | Code of the request being answered |
| op_err | output | 1 | Illegal command seen |

## Verification
The bench targets conflict misses on one index. A controller that lets a fetch set the dirty bit would send a spurious write-back when the conflicting write arrives. One that forgets a dirty victim would send a fetch with no write ahead of it. In exclusive mode it checks that a fetch hit removes the line, so a second fetch goes to the parent. It also checks that a fetch miss leaves the resident line in place; a controller that evicts there turns the next write into a fetch-write. Exact hit latencies, echoing of child IDs, and the silent drop of the illegal code are checked as well; an off-by-one stall counter or a lost ID shows up at the response port.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  typedef enum logic [1:0] {
    OP_FETCH_RD = 2'b00,
    OP_FETCH_WR = 2'b01,
    OP_WRITE    = 2'b10,
    OP_BAD      = 2'b11
  } lcc_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STALL,
    S_EVICT,
    S_FETCH,
    S_WTHRU,
    S_WAIT
  } lcc_state_e;

  // Value loaded into the stall counter: the response leaves when it hits zero.
  function automatic int unsigned stall_load(logic [1:0] op, int unsigned lat_fetch,
                                             int unsigned lat_write);
    return ((op == OP_WRITE) ? lat_write : lat_fetch) - 1;
  endfunction

  // A child write miss is fetched as fetch-write; fetches pass unchanged.
  function automatic logic [1:0] parent_fetch_op(logic [1:0] op);
    return (op == OP_WRITE) ? OP_FETCH_WR : op;
  endfunction

endpackage

// File: rtl/lcc_tag_store.sv
module lcc_tag_store #(
  parameter int SETS  = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic             lk_dirty,
  output logic [TAG_W-1:0] lk_tag,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic             ins_dirty,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] dirty_idx
);

  logic [SETS-1:0]            valid_v;
  logic [SETS-1:0]            dirty_v;
  logic [SETS-1:0][TAG_W-1:0] tag_v;

  for (genvar g = 0; g < SETS; g++) begin : gen_set
    logic             valid_q, dirty_q;
    logic [TAG_W-1:0] tag_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
        tag_q   <= '0;
      end else if (ins_en && ins_idx == IDX_W'(g)) begin
        valid_q <= 1'b1;
        dirty_q <= ins_dirty;
        tag_q   <= ins_tag;
      end else if (inv_en && inv_idx == IDX_W'(g)) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
      end else if (dirty_en && dirty_idx == IDX_W'(g)) begin
        dirty_q <= 1'b1;
      end
    end
    assign valid_v[g] = valid_q;
    assign dirty_v[g] = dirty_q;
    assign tag_v[g]   = tag_q;
  end

  assign lk_valid = valid_v[lk_idx];
  assign lk_dirty = dirty_v[lk_idx];
  assign lk_tag   = tag_v[lk_idx];

  // R5 / R6: an invalidated set reads back empty on the next cycle
  p_inv_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !(ins_en && ins_idx == inv_idx)) |=> !valid_v[$past(inv_idx)]);

  // R10: an installed line is present with the installed tag
  p_ins_present_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> (valid_v[$past(ins_idx)] && tag_v[$past(ins_idx)] == $past(ins_tag)));

endmodule

// File: rtl/lcc_stall_timer.sv
module lcc_stall_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (en && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R3 / R8: the stall counts down by exactly one per enabled cycle
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !zero && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lower_cache_ctrl.sv
module lower_cache_ctrl
  import lcc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 2,
  parameter int IDX_W      = 3,
  parameter int ID_W       = 4,
  parameter int LAT_FETCH  = 3,
  parameter int LAT_WRITE  = 2,
  parameter bit INCLUSIVE  = 1'b1,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_op,
  output logic [ID_W-1:0]   rsp_id,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              par_req_valid,
  input  logic              par_req_ready,
  output logic [1:0]        par_req_op,
  output logic [ADDR_W-1:0] par_req_addr,
  input  logic              par_rsp_valid,
  input  logic [1:0]        par_rsp_op,
  output logic              op_err
);

  localparam int SETS    = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int LAT_MAX = (LAT_FETCH > LAT_WRITE) ? LAT_FETCH : LAT_WRITE;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [ADDR_W-1:0] line_of(logic [TAG_W-1:0] t, logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction

  lcc_state_e        state_q, state_d;
  logic [1:0]        op_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q, victim_q;
  logic              err_q;

  // Named internal events
  logic             lk_valid, lk_dirty, lk_hit;
  logic [TAG_W-1:0] lk_tag;
  logic             accept, acc_bad, acc_fetch, acc_write;
  logic             evict_now, wb_needed, take_now;
  logic             inv_en, dirty_en, ins_en, ins_dirty;
  logic             fetch_rsp, wt_ack, wb_fire, par_fire;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  lcc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(idx_of(req_addr)), .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_tag(lk_tag),
    .ins_en(ins_en), .ins_idx(idx_of(addr_q)), .ins_tag(tag_of(addr_q)), .ins_dirty(ins_dirty),
    .inv_en(inv_en), .inv_idx(idx_of(req_addr)),
    .dirty_en(dirty_en), .dirty_idx(idx_of(req_addr))
  );

  lcc_stall_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .en(state_q == S_STALL), .zero(tmr_zero)
  );

  assign accept    = (state_q == S_IDLE) && req_valid;
  assign acc_bad   = accept && req_op == OP_BAD;
  assign acc_fetch = accept && (req_op == OP_FETCH_RD || req_op == OP_FETCH_WR);
  assign acc_write = accept && req_op == OP_WRITE;
  assign lk_hit    = lk_valid && lk_tag == tag_of(req_addr);

  assign evict_now = !lk_hit && (acc_write || (acc_fetch && INCLUSIVE));
  assign wb_needed = evict_now && lk_valid && lk_dirty;
  assign take_now  = acc_fetch && lk_hit && !INCLUSIVE;
  assign inv_en    = (evict_now && lk_valid) || take_now;
  assign dirty_en  = acc_write && lk_hit && WRITE_BACK;

  assign fetch_rsp = (state_q == S_WAIT) && par_rsp_valid && par_rsp_op != OP_WRITE;
  assign wt_ack    = (state_q == S_WAIT) && par_rsp_valid && par_rsp_op == OP_WRITE && !WRITE_BACK;
  assign ins_en    = fetch_rsp && (INCLUSIVE || op_q == OP_WRITE);
  assign ins_dirty = (op_q == OP_WRITE) && WRITE_BACK;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (acc_fetch)      state_d = lk_hit ? S_STALL : (wb_needed ? S_EVICT : S_FETCH);
        else if (acc_write) state_d = lk_hit ? (WRITE_BACK ? S_STALL : S_WTHRU)
                                             : (wb_needed ? S_EVICT : S_FETCH);
      end
      S_STALL: if (tmr_zero)      state_d = S_IDLE;
      S_EVICT: if (par_req_ready) state_d = S_FETCH;
      S_FETCH: if (par_req_ready) state_d = S_WAIT;
      S_WTHRU: if (par_req_ready) state_d = S_WAIT;
      S_WAIT: begin
        if (fetch_rsp)   state_d = (op_q == OP_WRITE && !WRITE_BACK) ? S_WTHRU : S_STALL;
        else if (wt_ack) state_d = S_STALL;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign tmr_load = (state_d == S_STALL) && (state_q != S_STALL);
  assign tmr_val  = CNT_W'(stall_load((state_q == S_IDLE) ? req_op : op_q, LAT_FETCH, LAT_WRITE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= '0;
      id_q     <= '0;
      addr_q   <= '0;
      victim_q <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= acc_bad;
      if (accept) begin
        op_q     <= req_op;
        id_q     <= req_id;
        addr_q   <= req_addr;
        victim_q <= line_of(lk_tag, idx_of(req_addr));
      end
    end
  end

  always_comb begin
    par_req_valid = 1'b0;
    par_req_op    = OP_WRITE;
    par_req_addr  = line_of(tag_of(addr_q), idx_of(addr_q));
    unique case (state_q)
      S_EVICT: begin par_req_valid = 1'b1; par_req_addr = victim_q; end
      S_FETCH: begin par_req_valid = 1'b1; par_req_op = parent_fetch_op(op_q); end
      S_WTHRU: par_req_valid = 1'b1;
      default: ;
    endcase
  end

  assign par_fire  = par_req_valid && par_req_ready;
  assign wb_fire   = par_fire && state_q == S_EVICT;
  assign req_ready = (state_q == S_IDLE);
  assign rsp_valid = (state_q == S_STALL) && tmr_zero;
  assign rsp_op    = op_q;
  assign rsp_id    = id_q;
  assign rsp_addr  = addr_q;
  assign op_err    = err_q;

  // R12: after a response the controller is ready for the next request
  p_ready_after_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  // R12: a stalled parent request holds its command and address
  p_par_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (par_req_valid && !par_req_ready) |=> (par_req_valid && $stable(par_req_op) && $stable(par_req_addr)));

  // R2: an illegal command yields no response and no parent traffic
  p_bad_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> (!rsp_valid && !par_req_valid && req_ready));

  // R6: a victim write-back is followed at once by the fetch
  p_wb_then_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> (par_req_valid && par_req_op != OP_WRITE));

  // R4: a fill caused by a fetch is installed clean
  p_fetch_fill_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && op_q != OP_WRITE) |-> !ins_dirty);

  // R9: without write-back nothing is ever marked dirty
  p_wt_never_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_en || (ins_en && ins_dirty)) |-> WRITE_BACK);

endmodule

// File: tb/lower_cache_ctrl_test.sv
module lcc_parent_model #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_op,
  output logic [15:0]       n_wr,
  output logic [15:0]       n_fr,
  output logic [15:0]       n_fw,
  output logic [1:0]        hist0,
  output logic [1:0]        hist1,
  output logic [ADDR_W-1:0] last_wr,
  output logic [ADDR_W-1:0] last_f
);
  logic [2:0]       pv;
  logic [2:0][1:0]  pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0; pop <= '0; n_wr <= '0; n_fr <= '0; n_fw <= '0;
      hist0 <= 2'b11; hist1 <= 2'b11; last_wr <= '0; last_f <= '0;
    end else begin
      pv  <= {pv[1:0], req_valid};
      pop <= {pop[1:0], req_op};
      if (req_valid) begin
        hist0 <= req_op;
        hist1 <= hist0;
        if (req_op == 2'b10) begin n_wr <= n_wr + 1'b1; last_wr <= req_addr; end
        else begin
          last_f <= req_addr;
          if (req_op == 2'b00) n_fr <= n_fr + 1'b1;
          else                 n_fw <= n_fw + 1'b1;
        end
      end
    end
  end
  assign rsp_valid = pv[2];
  assign rsp_op    = pop[2];
endmodule

module lower_cache_ctrl_test;
  localparam logic [15:0] A = 16'h0010;  // index 4, tag 0
  localparam logic [15:0] B = 16'h0030;  // index 4, tag 1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  // inclusive / write-back side
  logic a_rv = 0, a_rdy, a_sv, a_pv, a_prv, a_err;
  logic [1:0] a_op = 0, a_sop, a_pop, a_prop;
  logic [3:0] a_id = 0, a_sid;
  logic [15:0] a_ad = 0, a_sad, a_pad;
  logic [15:0] a_nwr, a_nfr, a_nfw, a_lw, a_lf;
  logic [1:0] a_h0, a_h1;
  // exclusive / write-through side
  logic x_rv = 0, x_rdy, x_sv, x_pv, x_prv, x_err;
  logic [1:0] x_op = 0, x_sop, x_pop, x_prop;
  logic [3:0] x_id = 0, x_sid;
  logic [15:0] x_ad = 0, x_sad, x_pad;
  logic [15:0] x_nwr, x_nfr, x_nfw, x_lw, x_lf;
  logic [1:0] x_h0, x_h1;

  lower_cache_ctrl #(.INCLUSIVE(1'b1), .WRITE_BACK(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(a_rv), .req_ready(a_rdy), .req_op(a_op),
    .req_id(a_id), .req_addr(a_ad), .rsp_valid(a_sv), .rsp_op(a_sop), .rsp_id(a_sid),
    .rsp_addr(a_sad), .par_req_valid(a_pv), .par_req_ready(1'b1), .par_req_op(a_pop),
    .par_req_addr(a_pad), .par_rsp_valid(a_prv), .par_rsp_op(a_prop), .op_err(a_err));
  lcc_parent_model pm_a (.clk(clk), .rst_n(rst_n), .req_valid(a_pv), .req_op(a_pop),
    .req_addr(a_pad), .rsp_valid(a_prv), .rsp_op(a_prop), .n_wr(a_nwr), .n_fr(a_nfr),
    .n_fw(a_nfw), .hist0(a_h0), .hist1(a_h1), .last_wr(a_lw), .last_f(a_lf));

  lower_cache_ctrl #(.INCLUSIVE(1'b0), .WRITE_BACK(1'b0)) uut_x (
    .clk(clk), .rst_n(rst_n), .req_valid(x_rv), .req_ready(x_rdy), .req_op(x_op),
    .req_id(x_id), .req_addr(x_ad), .rsp_valid(x_sv), .rsp_op(x_sop), .rsp_id(x_sid),
    .rsp_addr(x_sad), .par_req_valid(x_pv), .par_req_ready(1'b1), .par_req_op(x_pop),
    .par_req_addr(x_pad), .par_rsp_valid(x_prv), .par_rsp_op(x_prop), .op_err(x_err));
  lcc_parent_model pm_x (.clk(clk), .rst_n(rst_n), .req_valid(x_pv), .req_op(x_pop),
    .req_addr(x_pad), .rsp_valid(x_prv), .rsp_op(x_prop), .n_wr(x_nwr), .n_fr(x_nfr),
    .n_fw(x_nfw), .hist0(x_h0), .hist1(x_h1), .last_wr(x_lw), .last_f(x_lf));

  // results of the last request
  int r_cyc; bit r_seen, r_busy, r_err;
  logic [1:0] r_op; logic [3:0] r_id; logic [15:0] r_ad;
  int d_wr, d_fr, d_fw;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_req(input bit sel, input logic [1:0] op, input logic [3:0] id,
                         input logic [15:0] addr, input int limit);
    int wr0, fr0, fw0;
    wr0 = sel ? int'(x_nwr) : int'(a_nwr);
    fr0 = sel ? int'(x_nfr) : int'(a_nfr);
    fw0 = sel ? int'(x_nfw) : int'(a_nfw);
    r_seen = 0; r_busy = 0; r_err = 0; r_cyc = 0;
    @(negedge clk);
    if (sel) begin x_rv = 1; x_op = op; x_id = id; x_ad = addr; end
    else     begin a_rv = 1; a_op = op; a_id = id; a_ad = addr; end
    @(posedge clk);
    #1;
    a_rv = 0; x_rv = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (!(sel ? x_rdy : a_rdy)) r_busy = 1;
      if (sel ? x_err : a_err) r_err = 1;
      if (sel ? x_sv : a_sv) begin
        r_seen = 1; r_cyc = i;
        r_op = sel ? x_sop : a_sop;
        r_id = sel ? x_sid : a_sid;
        r_ad = sel ? x_sad : a_sad;
        break;
      end
    end
    d_wr = (sel ? int'(x_nwr) : int'(a_nwr)) - wr0;
    d_fr = (sel ? int'(x_nfr) : int'(a_nfr)) - fr0;
    d_fw = (sel ? int'(x_nfw) : int'(a_nfw)) - fw0;
  endtask

  task automatic t_reset();
    check(a_rdy == 1'b1, "R1 ready", a_rdy, 1);
    check(a_sv == 1'b0, "R1 rsp_valid", a_sv, 0);
    check(a_pv == 1'b0, "R1 par_req_valid", a_pv, 0);
    check(a_err == 1'b0, "R1 op_err", a_err, 0);
  endtask

  task automatic t_incl_fetch_miss();
    run_req(0, 2'b00, 4'd5, A, 60);
    check(r_seen, "R6 fetch miss answered", r_seen, 1);
    check(r_id == 4'd5, "R11 child id", r_id, 5);
    check(r_op == 2'b00 && r_ad == A, "R11 op/addr echo", {r_op, r_ad}, {2'b00, A});
    check(d_fr == 1 && d_wr == 0, "R6 fetch forwarded unchanged", d_fr, 1);
    check(a_lf == A, "R6 fetch address", a_lf, A);
    check(r_busy, "R12 busy while in flight", r_busy, 1);
  endtask

  task automatic t_incl_fetch_hit();
    run_req(0, 2'b00, 4'd6, A, 60);
    check(r_cyc == 3, "R3 fetch hit latency", r_cyc, 3);
    check(d_fr + d_fw + d_wr == 0, "R3 hit no parent traffic", d_fr + d_fw + d_wr, 0);
    check(r_id == 4'd6, "R11 id on hit", r_id, 6);
  endtask

  task automatic t_write_miss_clean_victim();
    run_req(0, 2'b10, 4'd1, B, 60);
    check(d_wr == 0, "R4 fetched line not dirty", d_wr, 0);
    check(d_fw == 1 && a_lf == B, "R10 write miss fetch-write", d_fw, 1);
  endtask

  task automatic t_write_hit_wb();
    run_req(0, 2'b10, 4'd2, B, 60);
    check(r_cyc == 2, "R8 write hit latency", r_cyc, 2);
    check(d_wr + d_fr + d_fw == 0, "R8 write-back hit silent", d_wr + d_fr + d_fw, 0);
  endtask

  task automatic t_dirty_victim();
    run_req(0, 2'b01, 4'd3, A, 60);
    check(d_wr == 1 && a_lw == B, "R6 dirty victim written back", a_lw, B);
    check(a_h1 == 2'b10 && a_h0 == 2'b01, "R6 write-back before fetch", {a_h1, a_h0}, 4'b1001);
    check(r_op == 2'b01, "R11 op echo fetch-write", r_op, 1);
  endtask

  task automatic t_illegal();
    run_req(0, 2'b11, 4'd7, A, 10);
    check(r_err, "R2 op_err raised", r_err, 1);
    check(!r_seen, "R2 no response", r_seen, 0);
    check(d_wr + d_fr + d_fw == 0, "R2 no parent traffic", d_wr + d_fr + d_fw, 0);
    run_req(0, 2'b00, 4'd8, A, 60);
    check(r_cyc == 3 && r_id == 4'd8, "R2 ready again after drop", r_cyc, 3);
  endtask

  task automatic t_excl_no_alloc();
    run_req(1, 2'b00, 4'd1, A, 60);
    check(d_fr == 1, "R7 exclusive fetch miss", d_fr, 1);
    run_req(1, 2'b00, 4'd1, A, 60);
    check(d_fr == 1, "R7 not installed", d_fr, 1);
  endtask

  task automatic t_wt_writes();
    run_req(1, 2'b10, 4'd2, B, 60);
    check(d_fw == 1 && d_wr == 1, "R10 write miss then forward", d_fw * 10 + d_wr, 11);
    check(x_h1 == 2'b01 && x_h0 == 2'b10, "R10 fetch-write before write", {x_h1, x_h0}, 4'b0110);
    run_req(1, 2'b10, 4'd3, B, 60);
    check(r_seen && d_fw == 0 && d_wr == 1 && x_lw == B, "R9 write-through hit", d_wr, 1);
  endtask

  task automatic t_excl_keeps_resident();
    run_req(1, 2'b00, 4'd4, A, 60);
    check(d_fr == 1 && d_wr == 0, "R7 no eviction on fetch miss", d_wr, 0);
    run_req(1, 2'b10, 4'd4, B, 60);
    check(d_fw == 0, "R7 resident line still hits", d_fw, 0);
  endtask

  task automatic t_excl_take();
    run_req(1, 2'b00, 4'd9, B, 60);
    check(r_cyc == 3 && d_fr == 0, "R5 fetch hit in exclusive", r_cyc, 3);
    run_req(1, 2'b00, 4'd9, B, 60);
    check(d_fr == 1, "R5 line taken by fetch hit", d_fr, 1);
    run_req(1, 2'b10, 4'd9, B, 60);
    check(d_wr == 1 && d_fw == 1, "R9 no dirty write-back ever", d_wr, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_incl_fetch_miss();
    t_incl_fetch_hit();
    t_write_miss_clean_victim();
    t_write_hit_wb();
    t_dirty_victim();
    t_illegal();
    t_excl_no_alloc();
    t_wt_writes();
    t_excl_keeps_resident();
    t_excl_take();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule